// File: doc/BRIEF.md
# Vector Predication Write-Back Merge

This block sits at the write-back end of a vector datapath with `LANES` lanes of `EW` bits each. For every lane it decides whether the freshly computed result is written, whether the lane's previous destination contents are kept, or whether the lane is cleared to zero. It makes that choice from four inputs: a start index, an active vector length, a per-lane mask and a flag that marks the instruction as unmasked.

Each lane falls into exactly one of four classes. Lanes below the start index are skipped. Lanes from the start index up to the vector length are either enabled or masked off. Lanes at or beyond the vector length form the tail. Only enabled lanes take the new result and may forward an exception request. The unit reports whether any such request survived, and which surviving lane has the lowest index. Skipped and masked-off lanes keep their old value. Tail lanes are cleared whether or not the operation is maskable.

All results are registered. A request presented with `valid_in` high appears on the outputs one clock later, marked by `valid_out`.

Top module: `vpm_merge_unit`

## Requirements
- R1: A lane with index below `vstart_in` (skipped) keeps its old destination value, has `wr_en_out` clear and never raises an exception. This holds even when the lane also lies at or beyond the vector length.
- R2: A lane with `vstart_in` <= index < effective length that is enabled (`unmasked_in`=1, or `mask_in` bit at the lane index =1) takes its new result, and its `wr_en_out` bit is set.
- R3: A lane with `vstart_in` <= index < effective length, with `unmasked_in`=0 and its mask bit 0, keeps its old value and has `wr_en_out` clear.
- R4: A lane with index >= effective length and >= `vstart_in` outputs zero and has `wr_en_out` set.
- R5: When `unmasked_in`=1, `mask_in` has no effect on any output lane.
- R6: A `vl_in` larger than `LANES` behaves exactly as `vl_in` = `LANES`.
- R7: When `vstart_in` >= effective length, no lane is enabled. Lanes below `vstart_in` keep their old value, and lanes at or above both `vstart_in` and the effective length are zeroed.
- R8: `exc_req_in` is honoured only on enabled lanes. `exc_valid_out`=1 exactly when at least one enabled lane requests an exception, and `exc_lane_out` is then the lowest such lane index.
- R9: `valid_out` equals `valid_in` from the previous clock. Data, write-enable and exception outputs reflect the request captured at that edge.
- R10: A synchronous active-high `rst` clears `valid_out`, `wr_en_out` and `exc_valid_out` at the next clock edge. Reset wins over a simultaneous `valid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| vstart_in | input | CNTW | First lane to process |
| vl_in | input | CNTW | Active vector length (clamped to LANES) |
| unmasked_in | input | 1 | 1 = instruction ignores the mask |
| mask_in | input | LANES | Per-lane enable mask |
| new_data_in | input | LANES*EW | Computed results, lane i at bits [i*EW +: EW] |
| old_data_in | input | LANES*EW | Prior destination contents, same layout |
| exc_req_in | input | LANES | Per-lane exception request |
| valid_out | output | 1 | Result strobe, one cycle after valid_in |
| dest_out | output | LANES*EW | Merged destination vector |
| wr_en_out | output | LANES | Per-lane write enable (enabled and tail lanes) |
| exc_valid_out | output | 1 | An enabled lane requested an exception |
| exc_lane_out | output | LIDXW | Lowest enabled excepting lane |

## Verification
The properties compare each registered output with the inputs seen one edge earlier. They therefore assume that `vstart_in`, `vl_in`, the mask and both data vectors are stable around the edge where `valid_in` is sampled, and that they are plain unsigned counts. Values of `vl_in` above `LANES` are legal and are expected to clamp. The stimulus changes every input on the falling edge only, pulses `valid_in` for one cycle per request, and covers an over-range length, an empty length, a start equal to and beyond the length, and a start larger than any lane index.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  // Per-lane predication class
  typedef enum logic [1:0] {
    LC_SKIP = 2'd0,  // below start index
    LC_ON   = 2'd1,  // enabled, takes new result
    LC_OFF  = 2'd2,  // masked off, keeps old value
    LC_TAIL = 2'd3   // past vector length, zeroed
  } lane_cls_e;

endpackage

// File: rtl/vpm_lane_classify.sv
module vpm_lane_classify #(
  parameter int LANES = 8,
  parameter int CNTW  = 4
) (
  input  logic [CNTW-1:0]      vstart_i,
  input  logic [CNTW-1:0]      vl_i,
  input  logic                 unmasked_i,
  input  logic [LANES-1:0]     mask_i,
  output vpm_pkg::lane_cls_e   cls_o [LANES]
);

  localparam logic [CNTW-1:0] LANES_C = CNTW'(LANES);

  logic [CNTW-1:0] vl_eff;

  // Lengths beyond the lane count behave as the full vector
  always_comb begin
    vl_eff = (vl_i > LANES_C) ? LANES_C : vl_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [CNTW-1:0] IDX = CNTW'(g);
    always_comb begin
      if (IDX < vstart_i)                 cls_o[g] = vpm_pkg::LC_SKIP;
      else if (IDX >= vl_eff)             cls_o[g] = vpm_pkg::LC_TAIL;
      else if (unmasked_i || mask_i[g])   cls_o[g] = vpm_pkg::LC_ON;
      else                                cls_o[g] = vpm_pkg::LC_OFF;
    end
  end

endmodule

// File: rtl/vpm_lane_merge.sv
module vpm_lane_merge #(
  parameter int LANES = 8,
  parameter int EW    = 8
) (
  input  vpm_pkg::lane_cls_e     cls_i [LANES],
  input  logic [LANES*EW-1:0]    new_i,
  input  logic [LANES*EW-1:0]    old_i,
  output logic [LANES*EW-1:0]    dest_o,
  output logic [LANES-1:0]       we_o,
  output logic [LANES-1:0]       on_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (cls_i[g])
        vpm_pkg::LC_ON: begin
          dest_o[g*EW +: EW] = new_i[g*EW +: EW];
          we_o[g]            = 1'b1;
          on_o[g]            = 1'b1;
        end
        vpm_pkg::LC_TAIL: begin
          dest_o[g*EW +: EW] = '0;
          we_o[g]            = 1'b1;
          on_o[g]            = 1'b0;
        end
        default: begin
          dest_o[g*EW +: EW] = old_i[g*EW +: EW];
          we_o[g]            = 1'b0;
          on_o[g]            = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/vpm_exc_pick.sv
module vpm_exc_pick #(
  parameter int LANES = 8,
  parameter int LIDXW = 3
) (
  input  logic [LANES-1:0] req_i,
  input  logic [LANES-1:0] on_i,
  output logic             any_o,
  output logic [LIDXW-1:0] idx_o
);

  logic [LANES-1:0] live;

  always_comb begin
    live  = req_i & on_i;
    any_o = |live;
    idx_o = '0;
    // Walk downward so the lowest set lane is written last
    for (int i = LANES - 1; i >= 0; i--) begin
      if (live[i]) idx_o = LIDXW'(i);
    end
  end

endmodule

// File: rtl/vpm_merge_unit.sv
module vpm_merge_unit #(
  parameter int LANES = 8,
  parameter int EW    = 8,
  localparam int CNTW  = $clog2(LANES) + 1,
  localparam int LIDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic [CNTW-1:0]     vstart_in,
  input  logic [CNTW-1:0]     vl_in,
  input  logic                unmasked_in,
  input  logic [LANES-1:0]    mask_in,
  input  logic [LANES*EW-1:0] new_data_in,
  input  logic [LANES*EW-1:0] old_data_in,
  input  logic [LANES-1:0]    exc_req_in,
  output logic                valid_out,
  output logic [LANES*EW-1:0] dest_out,
  output logic [LANES-1:0]    wr_en_out,
  output logic                exc_valid_out,
  output logic [LIDXW-1:0]    exc_lane_out
);

  vpm_pkg::lane_cls_e  cls [LANES];
  logic [LANES*EW-1:0] dest_c;
  logic [LANES-1:0]    we_c;
  logic [LANES-1:0]    on_c;
  logic                exc_any_c;
  logic [LIDXW-1:0]    exc_idx_c;

  vpm_lane_classify #(.LANES(LANES), .CNTW(CNTW)) classify_i (
    .vstart_i   (vstart_in),
    .vl_i       (vl_in),
    .unmasked_i (unmasked_in),
    .mask_i     (mask_in),
    .cls_o      (cls)
  );

  vpm_lane_merge #(.LANES(LANES), .EW(EW)) merge_i (
    .cls_i  (cls),
    .new_i  (new_data_in),
    .old_i  (old_data_in),
    .dest_o (dest_c),
    .we_o   (we_c),
    .on_o   (on_c)
  );

  vpm_exc_pick #(.LANES(LANES), .LIDXW(LIDXW)) pick_i (
    .req_i (exc_req_in),
    .on_i  (on_c),
    .any_o (exc_any_c),
    .idx_o (exc_idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out     <= 1'b0;
      wr_en_out     <= '0;
      exc_valid_out <= 1'b0;
      exc_lane_out  <= '0;
      dest_out      <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        dest_out      <= dest_c;
        wr_en_out     <= we_c;
        exc_valid_out <= exc_any_c;
        exc_lane_out  <= exc_idx_c;
      end
    end
  end

endmodule

// File: rtl/vpm_merge_chk.sv
module vpm_merge_chk #(
  parameter int LANES = 8,
  parameter int EW    = 8,
  parameter int CNTW  = 4,
  parameter int LIDXW = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                valid_in,
  input logic [CNTW-1:0]     vstart_in,
  input logic [CNTW-1:0]     vl_in,
  input logic                unmasked_in,
  input logic [LANES-1:0]    mask_in,
  input logic [LANES*EW-1:0] new_data_in,
  input logic [LANES*EW-1:0] old_data_in,
  input logic [LANES-1:0]    exc_req_in,
  input logic                valid_out,
  input logic [LANES*EW-1:0] dest_out,
  input logic [LANES-1:0]    wr_en_out,
  input logic                exc_valid_out,
  input logic [LIDXW-1:0]    exc_lane_out
);

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (valid_out == $past(valid_in)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!valid_out && !exc_valid_out && (wr_en_out == '0)));

  for (genvar x = 0; x < LANES; x++) begin : g_lane
    localparam logic [CNTW-1:0] IDX = CNTW'(x);

    // R1
    skip_keep_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && (IDX < vstart_in)) |->
        (!wr_en_out[x] && dest_out[x*EW +: EW] == $past(old_data_in[x*EW +: EW])));

    // R2
    unmasked_take_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && unmasked_in && (IDX >= vstart_in) && (IDX < vl_in)) |->
        (wr_en_out[x] && dest_out[x*EW +: EW] == $past(new_data_in[x*EW +: EW])));

    // R3
    masked_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && !unmasked_in && !mask_in[x] &&
            (IDX >= vstart_in) && (IDX < vl_in)) |->
        (!wr_en_out[x] && dest_out[x*EW +: EW] == $past(old_data_in[x*EW +: EW])));

    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && (IDX >= vstart_in) && (IDX >= vl_in)) |->
        (wr_en_out[x] && dest_out[x*EW +: EW] == '0));

    // R8
    exc_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_out && exc_valid_out && exc_lane_out == LIDXW'(x)) |->
        ($past(exc_req_in[x]) && wr_en_out[x] && dest_out[x*EW +: EW] == $past(new_data_in[x*EW +: EW])));
  end

endmodule

bind vpm_merge_unit vpm_merge_chk #(
  .LANES(LANES), .EW(EW), .CNTW(CNTW), .LIDXW(LIDXW)
) chk_i (.*);

// File: tb/vpm_merge_unit_tb.sv
`timescale 1ns/1ps
module vpm_merge_unit_tb_top;

  localparam int LANES = 8;
  localparam int EW    = 8;
  localparam int CNTW  = 4;
  localparam int LIDXW = 3;
  localparam int NROWS = 10;

  typedef struct packed {
    logic [3:0] vs;
    logic [3:0] vl;
    logic       un;
    logic [7:0] mask;
    logic [7:0] exc;
    logic [7:0] we;
    logic [7:0] zr;
    logic       ev;
    logic [2:0] el;
  } vec_t;

  // vs, vl, unmasked, mask, exc_req | expected we, zeroed lanes, exc valid, exc lane
  localparam vec_t TAB [NROWS] = '{
    '{4'd0,  4'd8,  1'b1, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 3'd0},
    '{4'd0,  4'd5,  1'b0, 8'hAA, 8'h00, 8'hEA, 8'hE0, 1'b0, 3'd0},
    '{4'd2,  4'd6,  1'b1, 8'h00, 8'hFF, 8'hFC, 8'hC0, 1'b1, 3'd2},
    '{4'd0,  4'd12, 1'b0, 8'h0F, 8'hF0, 8'h0F, 8'h00, 1'b0, 3'd0},
    '{4'd5,  4'd3,  1'b1, 8'hFF, 8'hFF, 8'hE0, 8'hE0, 1'b0, 3'd0},
    '{4'd4,  4'd4,  1'b1, 8'h00, 8'hFF, 8'hF0, 8'hF0, 1'b0, 3'd0},
    '{4'd0,  4'd0,  1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 3'd0},
    '{4'd1,  4'd8,  1'b0, 8'h64, 8'hC6, 8'h64, 8'h00, 1'b1, 3'd2},
    '{4'd0,  4'd7,  1'b1, 8'h00, 8'h40, 8'hFF, 8'h80, 1'b1, 3'd6},
    '{4'd15, 4'd15, 1'b1, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd0}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                valid_in = 1'b0;
  logic [CNTW-1:0]     vstart_in = '0;
  logic [CNTW-1:0]     vl_in = '0;
  logic                unmasked_in = 1'b0;
  logic [LANES-1:0]    mask_in = '0;
  logic [LANES*EW-1:0] new_data_in = '0;
  logic [LANES*EW-1:0] old_data_in = '0;
  logic [LANES-1:0]    exc_req_in = '0;
  logic                valid_out;
  logic [LANES*EW-1:0] dest_out;
  logic [LANES-1:0]    wr_en_out;
  logic                exc_valid_out;
  logic [LIDXW-1:0]    exc_lane_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vpm_merge_unit #(.LANES(LANES), .EW(EW)) dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int r);
    case (r)
      0: return "R2 R5 full length unmasked";
      1: return "R3 R4 masked with tail";
      2: return "R1 R8 start offset";
      3: return "R6 R8 length clamp";
      4: return "R7 R1 start past length";
      5: return "R7 R4 start equals length";
      6: return "R4 empty length";
      7: return "R8 lowest enabled exception";
      8: return "R8 R4 single exception";
      default: return "R6 R7 start beyond lanes";
    endcase
  endfunction

  initial begin
    logic [LANES*EW-1:0] exp_d;
    repeat (3) @(negedge clk);
    check("R10 reset valid_out", 64'(valid_out), 64'd0);
    check("R10 reset wr_en_out", 64'(wr_en_out), 64'd0);
    check("R10 reset exc_valid_out", 64'(exc_valid_out), 64'd0);
    rst = 1'b0;

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      vstart_in   = TAB[r].vs;
      vl_in       = TAB[r].vl;
      unmasked_in = TAB[r].un;
      mask_in     = TAB[r].mask;
      exc_req_in  = TAB[r].exc;
      for (int i = 0; i < LANES; i++) begin
        new_data_in[i*EW +: EW] = 8'(8'hA0 + 8'(16 * r) + 8'(i) + 1);
        old_data_in[i*EW +: EW] = 8'(8'h50 + 8'(i));
      end
      for (int i = 0; i < LANES; i++)
        exp_d[i*EW +: EW] = TAB[r].zr[i] ? 8'h00 :
                            TAB[r].we[i] ? new_data_in[i*EW +: EW] : old_data_in[i*EW +: EW];
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      check({"R9 valid_out ", row_tag(r)}, 64'(valid_out), 64'd1);
      check({"dest ", row_tag(r)}, 64'(dest_out), 64'(exp_d));
      check({"wr_en ", row_tag(r)}, 64'(wr_en_out), 64'(TAB[r].we));
      check({"exc_valid ", row_tag(r)}, 64'(exc_valid_out), 64'(TAB[r].ev));
      if (TAB[r].ev)
        check({"exc_lane ", row_tag(r)}, 64'(exc_lane_out), 64'(TAB[r].el));
      @(negedge clk);
      check({"R9 valid_out drop ", row_tag(r)}, 64'(valid_out), 64'd0);
    end

    // R5: same unmasked request with two different masks gives the same result
    @(negedge clk);
    vstart_in = 4'd1; vl_in = 4'd6; unmasked_in = 1'b1; mask_in = 8'h00; exc_req_in = 8'h00;
    valid_in = 1'b1;
    @(negedge clk);
    exp_d = dest_out;
    check("R5 mask zero wr_en", 64'(wr_en_out), 64'hFE);
    mask_in = 8'h5A;
    @(negedge clk);
    valid_in = 1'b0;
    check("R5 mask ignored dest", 64'(dest_out), 64'(exp_d));
    check("R5 mask ignored wr_en", 64'(wr_en_out), 64'hFE);

    // R10: reset asserted together with a request
    @(negedge clk);
    vstart_in = 4'd0; vl_in = 4'd8; exc_req_in = 8'h01;
    valid_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10 reset beats valid_in", 64'(valid_out), 64'd0);
    check("R10 reset clears wr_en", 64'(wr_en_out), 64'd0);
    check("R10 reset clears exc_valid", 64'(exc_valid_out), 64'd0);
    valid_in = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule